// File: doc/BRIEF.md
# Multithreaded Context Register File

This block keeps the architectural registers of four hardware threads in one physical array. Each thread owns eight registers, and an entry is addressed by the pair {context number, register index}. Two combinational read ports and one write port each carry their own context number. Results that come back late from a long-latency unit therefore land in the thread that issued them, not in the thread that happens to be active.

A thread scheduler keeps an active-context pointer that the issue logic uses to address the read ports. Switching threads only means changing this pointer, so nothing is saved or restored and no cycle is lost. The scheduler has two modes. In fine-grain mode it moves to another ready thread on every clock and skips threads whose stall input is high. In coarse-grain mode it stays on one thread and changes only when the long-stall input is raised. Short stalls do not cause a switch in this mode. When every thread is stalled, the scheduler lowers its valid output and keeps the pointer where it is.

Top module: `ctx_rf_top`

## Requirements
- R1: The array holds 4 contexts of 8 registers each. A write changes only the entry named by {wr_ctx_i, wr_idx_i}, and every other entry keeps its value.
- R2: Read ports are combinational. rd_a_data_o and rd_b_data_o show the entry named by their own context and index inputs in the same cycle.
- R3: A write goes to the context on wr_ctx_i whatever the value of active_ctx_o.
- R4: A read of the entry being written in the same cycle returns the old value. The new value can be read from the next cycle on.
- R5: mode_i = 0 selects fine-grain mode. At each clock edge the pointer moves to the first thread with a low stall bit, searched in the order cur+1, cur+2, cur+3, cur (modulo 4). With no stalls it advances by one each cycle.
- R6: In fine-grain mode a thread whose stall_i bit is high is never selected while another thread is ready.
- R7: mode_i = 1 selects coarse-grain mode. When long_stall_i is low, the pointer holds at each edge whatever the value of stall_i.
- R8: In coarse-grain mode, when long_stall_i is high at an edge, the pointer moves by the same search as in R5.
- R9: If all four stall_i bits are high at an edge, in either mode, active_ctx_o holds and ctx_valid_o is low after that edge.
- R10: If any stall_i bit is low at an edge, ctx_valid_o is high after that edge.
- R11: While rst_ni is low, active_ctx_o is 0, ctx_valid_o is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = fine-grain, 1 = coarse-grain |
| stall_i | input | 4 | Per-thread stall, bit n for thread n |
| long_stall_i | input | 1 | Long-stall event on the active thread |
| wr_en_i | input | 1 | Write enable |
| wr_ctx_i | input | 2 | Write context |
| wr_idx_i | input | 3 | Write register index |
| wr_data_i | input | 32 | Write data |
| rd_a_ctx_i | input | 2 | Read port A context |
| rd_a_idx_i | input | 3 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_ctx_i | input | 2 | Read port B context |
| rd_b_idx_i | input | 3 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| active_ctx_o | output | 2 | Active context pointer |
| ctx_valid_o | output | 1 | Active context is ready to issue |

## Verification
The assertions check the following on every clock:
- the all-stalled hold with valid low (R9), the valid rule (R10) and the coarse-mode hold (R7);
- the single-step rotation in fine-grain mode when every thread is ready (R5), and that a stalled thread is never picked in fine-grain mode (R6);
- that data written on one cycle can be read on port A the next cycle (R4).

Only the bench scenarios show the following:
- a write into a context other than the active one (R3), and the isolation of all 32 entries from one another (R1);
- the old-value return for a read in the same cycle as a write to that entry (R4);
- the exact search order under mixed stall patterns and long-stall switches (R5, R8);
- the reset contents (R11).

// File: rtl/ctx_rf_pkg.sv
package ctx_rf_pkg;
  typedef enum logic {
    SCHED_FINE   = 1'b0,
    SCHED_COARSE = 1'b1
  } sched_mode_e;

  localparam int unsigned DEF_NUM_CTX = 4;
  localparam int unsigned DEF_NUM_REG = 8;
  localparam int unsigned DEF_DATA_W  = 32;
endpackage

// File: rtl/ctx_rr_pick.sv
// Round-robin search for a ready thread, starting after cur_i; cur_i is tried last.
module ctx_rr_pick #(
  parameter int unsigned NUM_CTX = 4,
  localparam int unsigned CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [CTX_W-1:0]   cur_i,
  input  logic [NUM_CTX-1:0] stall_i,
  output logic [CTX_W-1:0]   pick_o,
  output logic               any_o
);
  always_comb begin
    pick_o = cur_i;
    // walk from farthest to nearest so the nearest ready thread wins
    for (int k = NUM_CTX; k >= 1; k--) begin
      int unsigned cand;
      cand = (int'(cur_i) + k) % NUM_CTX;
      if (!stall_i[cand]) pick_o = CTX_W'(cand);
    end
    any_o = ~&stall_i;
  end
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
  import ctx_rf_pkg::*;
#(
  parameter int unsigned NUM_CTX = 4,
  localparam int unsigned CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  sched_mode_e        mode_i,
  input  logic [NUM_CTX-1:0] stall_i,
  input  logic               long_stall_i,
  output logic [CTX_W-1:0]   active_ctx_o,
  output logic               ctx_valid_o
);
  logic [CTX_W-1:0] cur_q, pick;
  logic             valid_q, any_ready, do_switch;

  ctx_rr_pick #(.NUM_CTX(NUM_CTX)) u_pick (
    .cur_i   (cur_q),
    .stall_i (stall_i),
    .pick_o  (pick),
    .any_o   (any_ready)
  );

  always_comb begin
    unique case (mode_i)
      SCHED_FINE:   do_switch = any_ready;
      SCHED_COARSE: do_switch = any_ready & long_stall_i;
      default:      do_switch = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (do_switch) cur_q <= pick;
      valid_q <= any_ready;
    end
  end

  assign active_ctx_o = cur_q;
  assign ctx_valid_o  = valid_q;
endmodule

// File: rtl/ctx_rf_array.sv
module ctx_rf_array #(
  parameter int unsigned NUM_CTX = 4,
  parameter int unsigned NUM_REG = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_RD  = 2,
  localparam int unsigned CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int unsigned IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
  localparam int unsigned ADDR_W = CTX_W + IDX_W,
  localparam int unsigned DEPTH  = NUM_CTX * NUM_REG
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [CTX_W-1:0]              wr_ctx_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [NUM_RD-1:0][CTX_W-1:0]  rd_ctx_i,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx_i,
  output logic [NUM_RD-1:0][DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] wr_addr;

  assign wr_addr = {wr_ctx_i, wr_idx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr] <= wr_data_i;
    end
  end

  // read before write: old contents are seen during a write cycle
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [ADDR_W-1:0] rd_addr;
    assign rd_addr      = {rd_ctx_i[p], rd_idx_i[p]};
    assign rd_data_o[p] = mem_q[rd_addr];
  end
endmodule

// File: rtl/ctx_rf_top.sv
module ctx_rf_top
  import ctx_rf_pkg::*;
#(
  parameter int unsigned NUM_CTX = DEF_NUM_CTX,
  parameter int unsigned NUM_REG = DEF_NUM_REG,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  localparam int unsigned CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int unsigned IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic [NUM_CTX-1:0] stall_i,
  input  logic               long_stall_i,
  input  logic               wr_en_i,
  input  logic [CTX_W-1:0]   wr_ctx_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [CTX_W-1:0]   rd_a_ctx_i,
  input  logic [IDX_W-1:0]   rd_a_idx_i,
  output logic [DATA_W-1:0]  rd_a_data_o,
  input  logic [CTX_W-1:0]   rd_b_ctx_i,
  input  logic [IDX_W-1:0]   rd_b_idx_i,
  output logic [DATA_W-1:0]  rd_b_data_o,
  output logic [CTX_W-1:0]   active_ctx_o,
  output logic               ctx_valid_o
);
  localparam int unsigned NUM_RD = 2;

  logic [NUM_RD-1:0][CTX_W-1:0]  rd_ctx;
  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
  sched_mode_e                   mode;

  assign rd_ctx      = {rd_b_ctx_i, rd_a_ctx_i};
  assign rd_idx      = {rd_b_idx_i, rd_a_idx_i};
  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign mode        = sched_mode_e'(mode_i);

  ctx_rf_array #(
    .NUM_CTX (NUM_CTX),
    .NUM_REG (NUM_REG),
    .DATA_W  (DATA_W),
    .NUM_RD  (NUM_RD)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_ctx_i  (wr_ctx_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .rd_ctx_i  (rd_ctx),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  ctx_sched #(.NUM_CTX(NUM_CTX)) u_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode),
    .stall_i      (stall_i),
    .long_stall_i (long_stall_i),
    .active_ctx_o (active_ctx_o),
    .ctx_valid_o  (ctx_valid_o)
  );
endmodule

// File: rtl/ctx_rf_chk.sv
module ctx_rf_chk #(
  parameter int unsigned NUM_CTX = 4,
  parameter int unsigned NUM_REG = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int unsigned IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_i,
  input logic [NUM_CTX-1:0] stall_i,
  input logic               long_stall_i,
  input logic               wr_en_i,
  input logic [CTX_W-1:0]   wr_ctx_i,
  input logic [IDX_W-1:0]   wr_idx_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [CTX_W-1:0]   rd_a_ctx_i,
  input logic [IDX_W-1:0]   rd_a_idx_i,
  input logic [DATA_W-1:0]  rd_a_data_o,
  input logic [CTX_W-1:0]   active_ctx_o,
  input logic               ctx_valid_o
);
  logic [NUM_CTX-1:0] stall_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= '0;
    else         stall_q <= stall_i;
  end

  a_r9_all_stalled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&stall_i) |=> (!ctx_valid_o && $stable(active_ctx_o)));

  a_r10_valid_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~&stall_i) |=> ctx_valid_o);

  a_r7_coarse_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !long_stall_i) |=> $stable(active_ctx_o));

  a_r5_fine_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && stall_i == '0) |=> (active_ctx_o == CTX_W'($past(active_ctx_o) + 1'b1)));

  a_r6_fine_skip_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && (~&stall_i)) |=> !stall_q[active_ctx_o]);

  a_r4_write_visible_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (({rd_a_ctx_i, rd_a_idx_i} != $past({wr_ctx_i, wr_idx_i}))
                 || (rd_a_data_o == $past(wr_data_i))));
endmodule

bind ctx_rf_top ctx_rf_chk #(
  .NUM_CTX (NUM_CTX),
  .NUM_REG (NUM_REG),
  .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/ctx_rf_top_tb.sv
module ctx_rf_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic [3:0]  stall_i = 4'hF;
  logic        long_stall_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_ctx_i = '0;
  logic [2:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  rd_a_ctx_i = '0;
  logic [2:0]  rd_a_idx_i = '0;
  logic [31:0] rd_a_data_o;
  logic [1:0]  rd_b_ctx_i = '0;
  logic [2:0]  rd_b_idx_i = '0;
  logic [31:0] rd_b_data_o;
  logic [1:0]  active_ctx_o;
  logic        ctx_valid_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // reference state
  logic [31:0] ref_mem [4][8];
  int          ref_ptr = 0;
  bit          ref_valid = 0;

  always #5 clk_i = ~clk_i;

  ctx_rf_top u_dut (.*);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int next_ready(int cur, logic [3:0] st);
    for (int k = 1; k <= 4; k++)
      if (!st[(cur + k) % 4]) return (cur + k) % 4;
    return cur;
  endfunction

  // one clock: drive at negedge, check combinational reads and current state, advance model
  task automatic cyc(logic md, logic [3:0] st, logic ls,
                     logic we, int wc, int wi, logic [31:0] wd,
                     int ac, int ai, int bc, int bi,
                     string trd, string tsc);
    @(negedge clk_i);
    mode_i = md; stall_i = st; long_stall_i = ls;
    wr_en_i = we; wr_ctx_i = 2'(wc); wr_idx_i = 3'(wi); wr_data_i = wd;
    rd_a_ctx_i = 2'(ac); rd_a_idx_i = 3'(ai); rd_b_ctx_i = 2'(bc); rd_b_idx_i = 3'(bi);
    #1;
    check(trd, "rd_a", rd_a_data_o, ref_mem[ac][ai]);
    check(trd, "rd_b", rd_b_data_o, ref_mem[bc][bi]);
    check(tsc, "active_ctx", 32'(active_ctx_o), 32'(ref_ptr));
    check(ref_valid ? "R10" : "R9", "ctx_valid", 32'(ctx_valid_o), 32'(ref_valid));
    if (we) ref_mem[wc][wi] = wd;
    if (&st) ref_valid = 0;
    else begin
      ref_valid = 1;
      if (!md || ls) ref_ptr = next_ready(ref_ptr, st);
    end
  endtask

  initial begin
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 8; r++) ref_mem[c][r] = '0;
    #3;
    // R11: reset state
    check("R11", "active_ctx", 32'(active_ctx_o), 0);
    check("R11", "ctx_valid", 32'(ctx_valid_o), 0);
    check("R11", "rd_a", rd_a_data_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R3/R4: write into context 2 while active is 0, read in same cycle sees old value
    cyc(0, 4'hF, 0, 1, 2, 5, 32'hA5A5_0001, 2, 5, 2, 5, "R4", "R9");
    cyc(0, 4'hF, 0, 0, 0, 0, 0, 2, 5, 0, 5, "R3", "R9");
    // R1: fill every entry with a distinct value, reading elsewhere each cycle
    for (int e = 0; e < 32; e++)
      cyc(1, 4'h0, 0, 1, e / 8, e % 8, 32'h1000_0000 + e * 32'h111,
          (e / 8 + 1) % 4, e % 8, e / 8, (e + 3) % 8, "R1", "R7");
    for (int e = 0; e < 32; e++)
      cyc(1, 4'h0, 0, 0, 0, 0, 0, e / 8, e % 8, (e / 8 + 2) % 4, 7 - e % 8, "R1", "R7");
    // R5: fine rotation, all ready
    for (int i = 0; i < 6; i++) cyc(0, 4'h0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R2", "R5");
    // R6: fine with stalled threads skipped
    for (int i = 0; i < 6; i++) cyc(0, 4'b0110, 0, 0, 0, 0, 0, 3, 3, 2, 2, "R2", "R6");
    for (int i = 0; i < 4; i++) cyc(0, 4'b1011, 0, 0, 0, 0, 0, 3, 3, 2, 2, "R2", "R6");
    // R9: all stalled holds pointer
    for (int i = 0; i < 3; i++) cyc(0, 4'hF, 0, 0, 0, 0, 0, 1, 2, 3, 4, "R2", "R9");
    cyc(0, 4'h0, 0, 0, 0, 0, 0, 1, 2, 3, 4, "R2", "R9");
    // R7: coarse hold despite short stalls
    for (int i = 0; i < 5; i++)
      cyc(1, 4'(i * 5), 0, 0, 0, 0, 0, 0, 1, 0, 2, "R2", "R7");
    // R8: coarse switch on long stall
    cyc(1, 4'h0, 1, 0, 0, 0, 0, 0, 1, 0, 2, "R2", "R8");
    cyc(1, 4'b0101, 1, 0, 0, 0, 0, 0, 1, 0, 2, "R2", "R8");
    cyc(1, 4'h0, 0, 0, 0, 0, 0, 0, 1, 0, 2, "R2", "R8");
    cyc(1, 4'hF, 1, 0, 0, 0, 0, 0, 1, 0, 2, "R2", "R9");
    cyc(1, 4'h0, 0, 0, 0, 0, 0, 0, 1, 0, 2, "R2", "R7");
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic md, ls, we;
      md = 1'($urandom);
      ls = ($urandom % 4) == 0;
      we = 1'($urandom);
      cyc(md, 4'($urandom & $urandom), ls, we, $urandom % 4, $urandom % 8, $urandom,
          $urandom % 4, $urandom % 8, $urandom % 4, $urandom % 8,
          "R2", md ? "R8" : "R6");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule